// File: doc/BRIEF.md
# Overflow-Driven Frequency Generator

This block is a numerically controlled oscillator. A 24-bit phase accumulator adds a programmable step on every enabled clock. When the sum carries out of the top bit, the wrapped remainder stays in the accumulator and an overflow event is raised. The output frequency is therefore step / 2^24 of the enabled clock rate, with sub-cycle phase kept from one period to the next.

Each overflow event drives a waveform pin in one of two ways. In pulse mode, the pin goes high and stays high for a programmed number of enabled clocks. In square mode, each event toggles a flip-flop, which gives a 50% duty square wave at half the event rate. A one-cycle overflow strobe is also brought out, so a neighbour block can count or time the events.

Top module: `nco_timer`

## Requirements
- R1: While `rst_n` is low (asynchronous), `ovf_stb` and `wave_out` are 0 and the accumulator is 0. After `rst_n` rises, the block stays in reset for two more rising edges and leaves reset on the third.
- R2: On each rising edge with `en` high, the accumulator becomes (accumulator + `step`) mod 2^24.
- R3: `ovf_stb` is high for exactly the one cycle that follows an enabled edge whose sum reached 2^24 or more. The remainder stays in the accumulator and is not cleared.
- R4: In pulse mode (`mode` = 0), `wave_out` is high in the same cycle as `ovf_stb`.
- R5: In pulse mode, a pulse lasts `pulse_len` enabled cycles, and a `pulse_len` of 0 lasts one cycle.
- R6: In pulse mode, an overflow during an active pulse restarts the length count and keeps `wave_out` high.
- R7: In square mode (`mode` = 1), `wave_out` inverts in the cycle `ovf_stb` is high and is otherwise unchanged.
- R8: While `en` is low, the accumulator, the pulse count and `wave_out` hold their values, and `ovf_stb` stays 0.
- R9: A new `step` value is used from the next enabled edge on and leaves the accumulator contents as they are.
- R10: Both waveform generators run in all modes, and `mode` only selects which one drives `wave_out`, without registering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the whole datapath |
| step | input | 24 | Phase increment added on each enabled edge |
| pulse_len | input | 16 | Pulse width in enabled cycles (0 means 1) |
| mode | input | 1 | 0 = pulse mode, 1 = square mode |
| wave_out | output | 1 | Waveform output |
| ovf_stb | output | 1 | One-cycle accumulator overflow strobe |

## Verification
The overflow strobe and both waveform registers are driven from the same carry term. All of them change at the rising edge that ends the enabled cycle in which the carry happened, so each output is due one edge after its stimulus. The only exception is the reset release, which takes effect two edges later than the pin. The bench changes inputs on falling edges and steps an arithmetic model at each rising edge. It compares the outputs at the falling edge that follows, so every result is sampled in the cycle it is due and half a period away from the edge that made it.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic {
    MODE_PULSE  = 1'b0,
    MODE_SQUARE = 1'b1
  } nco_mode_e;
endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

  // Release only after the full chain has filled (R1)
  p_release_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  output logic             evt_o,
  output logic             ovf_o
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0] sum;
  logic             ovf_q, ovf_d;
  logic             carry;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, step};
    carry = sum[ACC_W];
    acc_d = acc_q;
    ovf_d = 1'b0;
    if (en) begin
      acc_d = sum[ACC_W-1:0];
      ovf_d = carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign evt_o = ovf_d;
  assign ovf_o = ovf_q;

  // Strobe marks exactly the enabled edges where the phase wrapped (R3)
  p_wrap_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ovf_q == (acc_q < $past(acc_q))));
  // Disabled cycles leave phase untouched and raise no strobe (R8)
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(acc_q) && !ovf_q));
endmodule

// File: rtl/nco_pulse.sv
module nco_pulse #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [LEN_W-1:0] len,
  output logic             out_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] load_val;
  logic             out_q, out_d;

  always_comb begin
    load_val = (len == '0) ? '0 : len - LEN_W'(1);
    cnt_d    = cnt_q;
    out_d    = out_q;
    if (evt) begin
      out_d = 1'b1;
      cnt_d = load_val;
    end else if (en && out_q) begin
      if (cnt_q == '0) out_d = 1'b0;
      else             cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign out_o = out_q;

  // Every event leaves the pulse high (R4, R6)
  p_pulse_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> out_q);
  // A pulse only ends once its count is spent and no event re-armed it (R5)
  p_pulse_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_q) |-> ($past(cnt_q) == '0 && !$past(evt)));
  // No enable, no change (R8)
  p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_q) && $stable(cnt_q)));
endmodule

// File: rtl/nco_square.sv
module nco_square (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic out_o
);
  logic out_q, out_d;

  always_comb out_d = out_q ^ evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign out_o = out_q;

  // Toggle on each event, hold otherwise (R7)
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (out_q != $past(out_q)));
  p_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(out_q));
endmodule

// File: rtl/nco_timer.sv
module nco_timer #(
  parameter int ACC_W     = 24,
  parameter int LEN_W     = 16,
  parameter int RST_STAGE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] step,
  input  logic [LEN_W-1:0] pulse_len,
  input  logic             mode,
  output logic             wave_out,
  output logic             ovf_stb
);
  import nco_pkg::*;

  logic      rst_int_n;
  logic      evt;
  logic      pulse_wave;
  logic      square_wave;
  nco_mode_e mode_sel;

  nco_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_int_n)
  );

  nco_accum #(.ACC_W(ACC_W)) u_accum (
    .clk  (clk),
    .rst_n(rst_int_n),
    .en   (en),
    .step (step),
    .evt_o(evt),
    .ovf_o(ovf_stb)
  );

  nco_pulse #(.LEN_W(LEN_W)) u_pulse (
    .clk  (clk),
    .rst_n(rst_int_n),
    .en   (en),
    .evt  (evt),
    .len  (pulse_len),
    .out_o(pulse_wave)
  );

  nco_square u_square (
    .clk  (clk),
    .rst_n(rst_int_n),
    .evt  (evt),
    .out_o(square_wave)
  );

  always_comb begin
    mode_sel = nco_mode_e'(mode);
    wave_out = (mode_sel == MODE_SQUARE) ? square_wave : pulse_wave;
  end

  // Pulse output is high whenever the strobe is (R4)
  p_pulse_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ovf_stb && mode == 1'b0) |-> wave_out);
endmodule

// File: tb/test_nco_timer.sv
`timescale 1ns/1ps
module test_nco_timer;
  localparam int ACC_W = 24;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en;
  logic [ACC_W-1:0] step;
  logic [LEN_W-1:0] pulse_len;
  logic             mode;
  logic             wave_out;
  logic             ovf_stb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  longint           m_acc;
  int               m_cnt;
  bit               m_pulse, m_sq, m_ovf;

  always #2 clk = ~clk;

  nco_timer #(.ACC_W(ACC_W), .LEN_W(LEN_W)) i_nco_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .pulse_len(pulse_len), .mode(mode),
    .wave_out(wave_out), .ovf_stb(ovf_stb)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One enabled/disabled clock: model steps at the rising edge, compare at the falling one
  task automatic tick(input string tag);
    longint sum;
    bit     evt;
    @(posedge clk);
    sum = m_acc + longint'(step);
    evt = en && (sum >= (longint'(1) << ACC_W));
    if (en) m_acc = sum % (longint'(1) << ACC_W);
    m_ovf = evt;
    if (evt) begin
      m_pulse = 1'b1;
      m_cnt   = (pulse_len == 0) ? 0 : int'(pulse_len) - 1;
    end else if (en && m_pulse) begin
      if (m_cnt == 0) m_pulse = 1'b0;
      else            m_cnt--;
    end
    if (evt) m_sq = ~m_sq;
    @(negedge clk);
    check({tag, " R3 strobe"}, ovf_stb, m_ovf);
    check({tag, " R10 wave"}, wave_out, mode ? m_sq : m_pulse);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; step = '0; pulse_len = '0; mode = 1'b0;
    m_acc = 0; m_cnt = 0; m_pulse = 0; m_sq = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    check("R1 reset strobe", ovf_stb, 1'b0);
    check("R1 reset wave", wave_out, 1'b0);
    rst_n = 1'b1;
    // R1: enable during the synchroniser delay must be ignored for two edges
    en = 1'b1; step = 24'hFFFFFF;
    @(posedge clk); @(negedge clk);
    check("R1 sync edge1", ovf_stb, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R1 sync edge2", ovf_stb, 1'b0);
    en = 1'b0;
    tick("R1 idle");

    // Pulse mode sweep: R2 R4 R5 R6 (step FFFFFF overflows almost every cycle)
    mode = 1'b0; en = 1'b1;
    for (int s = 0; s < 5; s++) begin
      case (s)
        0: step = 24'h800000;
        1: step = 24'hFFFFFF;
        2: step = 24'h555556;
        3: step = 24'h300001;
        default: step = 24'h0A0001;
      endcase
      for (int l = 0; l < 6; l++) begin
        pulse_len = LEN_W'(l);
        for (int c = 0; c < 40; c++) tick("R2/R4/R5/R6 pulse");
      end
    end

    // Square mode sweep: R7
    mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      step = 24'h1 << (20 + s);
      for (int c = 0; c < 60; c++) tick("R7 square");
      step = 24'hABCDEF;
      for (int c = 0; c < 30; c++) tick("R7 square");
    end

    // Enable gating with a long pulse: R8
    mode = 1'b0; pulse_len = 16'd7; step = 24'h700000;
    for (int c = 0; c < 120; c++) begin
      en = (c % 3) != 0;
      tick("R8 gated");
    end
    en = 1'b0;
    for (int c = 0; c < 10; c++) tick("R8 hold");
    en = 1'b1; mode = 1'b1;
    for (int c = 0; c < 30; c++) tick("R8 resume");

    // Step changes on the fly: R9
    en = 1'b1;
    for (int c = 0; c < 200; c++) begin
      if (c % 5 == 0) step = ACC_W'((c * 24'h13579B) ^ 24'h2468AC);
      mode = (c % 17) > 8;
      pulse_len = LEN_W'(c % 4);
      tick("R9 retune");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule